// File: doc/BRIEF.md
# Byte-to-Word Packer with Zero Padding

The block takes an ordered stream of bytes, one byte per handshake with a flag on the final byte, and gathers them into words of `DATA_BYTES` bytes for a memory write-back path. Each output byte lane has its own small FIFO. The bytes are dealt to these lane FIFOs in turn, so byte `i` of a stream always lands in lane `i mod DATA_BYTES` of word `i / DATA_BYTES`.

A stream may end part-way through a word. In that case the lanes that received no byte are driven with zero, and a full-width word is emitted with the last flag set. After a final byte has been accepted, the input is held off until that final word has left. The next stream therefore always begins in lane 0.

The input and the output each use a valid/ready handshake with a last flag. Lane FIFO depth is a parameter separate from the bus width.

Top module: `byte_word_packer`

## Requirements
- R1: Out of reset, out_valid_o is 0 and in_ready_o is 1.
- R2: Input byte `i` of a stream (counting from 0) appears in bits `8*(i mod DATA_BYTES)+7 : 8*(i mod DATA_BYTES)` of output word `i / DATA_BYTES` of that stream, preserving arrival order.
- R3: Each accepted input byte is stored in exactly one lane FIFO and emitted exactly once. A stream of `n` bytes produces exactly `ceil(n / DATA_BYTES)` output words.
- R4: When a stream ends with `k < DATA_BYTES` bytes in its final word, lanes `k` through `DATA_BYTES-1` of that word are 8'h00.
- R5: out_last_o is 1 on the word holding the final input byte, whether or not that word is padded, and 0 on every other word.
- R6: out_valid_o is asserted only when every lane holds a byte, or when the head word is the final partial word of a stream. No partial word is emitted in the middle of a stream.
- R7: in_ready_o is 0 while the lane FIFO selected for the next byte is full. With output stalled, exactly `DATA_BYTES*FIFO_DEPTH` bytes are accepted.
- R8: Once a byte with in_last_i is accepted, in_ready_o stays 0 until the word carrying out_last_o is accepted. The following stream starts at lane 0.
- R9: While out_valid_o is 1 and out_ready_i is 0, out_valid_o, out_data_o and out_last_o remain stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Input byte |
| in_valid_i | input | 1 | Input byte valid |
| in_last_i | input | 1 | Marks the final byte of a stream |
| in_ready_o | output | 1 | Block can take a byte |
| out_data_o | output | 8*DATA_BYTES | Packed word; lane k is bits 8k+7:8k |
| out_valid_o | output | 1 | Output word valid |
| out_last_o | output | 1 | Word holds the stream's final byte |
| out_ready_i | input | 1 | Consumer takes the word |

## Verification
A byte accepted at a rising edge is written into its lane FIFO at that same edge. If it completes a word, or is a final byte, out_valid_o rises directly after that edge, so the word is due zero cycles after the accepting edge. The word then stays on the outputs until the edge where out_ready_i is high. After a final byte, in_ready_o is low from the next edge onward. The bench changes inputs and samples outputs only on falling edges, and treats a handshake as done on the rising edge that follows a falling edge where both valid and ready were seen high. Expected words are compared in order against a queue the bench builds from the byte stream.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
  typedef struct packed {
    logic       last;
    logic [7:0] data;
  } lane_entry_t;
endpackage

// File: rtl/bwp_lane_fifo.sv
module bwp_lane_fifo
  import bwp_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  lane_entry_t wdata_i,
  input  logic        pop_i,
  output lane_entry_t rdata_o,
  output logic        empty_o,
  output logic        full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  lane_entry_t         mem [DEPTH];
  logic [PW-1:0]       wr_q, rd_q;
  logic [CW-1:0]       cnt_q;
  logic                do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/bwp_lane_ctrl.sv
module bwp_lane_ctrl #(
  parameter int unsigned DATA_BYTES = 4,
  localparam int unsigned LW = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  input  logic                  in_last_i,
  input  logic [DATA_BYTES-1:0] lane_full_i,
  input  logic                  out_fire_i,
  input  logic                  out_last_i,
  output logic                  in_ready_o,
  output logic [DATA_BYTES-1:0] push_o,
  output logic                  flush_pend_o,
  output logic [LW-1:0]         flush_idx_o
);
  logic [LW-1:0] ptr_q;
  logic          in_fire;

  assign in_ready_o = !flush_pend_o && !lane_full_i[ptr_q];
  assign in_fire    = in_valid_i && in_ready_o;

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_push
    assign push_o[k] = in_fire && (ptr_q == LW'(k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q        <= '0;
      flush_pend_o <= 1'b0;
      flush_idx_o  <= '0;
    end else begin
      if (in_fire) begin
        if (in_last_i || ptr_q == LW'(DATA_BYTES - 1)) ptr_q <= '0;
        else                                           ptr_q <= ptr_q + 1'b1;
        if (in_last_i) begin
          flush_pend_o <= 1'b1;
          flush_idx_o  <= ptr_q;
        end
      end
      // input is held off while pending, so set and clear never coincide
      if (out_fire_i && out_last_i) flush_pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bwp_word_asm.sv
module bwp_word_asm
  import bwp_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 4,
  localparam int unsigned LW = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  lane_entry_t [DATA_BYTES-1:0] head_i,
  input  logic [DATA_BYTES-1:0]        empty_i,
  input  logic                         flush_pend_i,
  input  logic [LW-1:0]                flush_idx_i,
  input  logic                         out_ready_i,
  output logic [8*DATA_BYTES-1:0]      out_data_o,
  output logic                         out_valid_o,
  output logic                         out_last_o,
  output logic [DATA_BYTES-1:0]        pop_o,
  output logic                         out_fire_o
);
  logic                  all_full, nxt_empty, partial;
  logic [DATA_BYTES-1:0] used, lane_last;

  assign all_full = ~|empty_i;

  // head word is the padded tail when the lane above the final byte is empty
  always_comb begin
    nxt_empty = 1'b0;
    for (int k = 0; k < DATA_BYTES - 1; k++) begin
      if (flush_idx_i == LW'(k)) nxt_empty = empty_i[k+1];
    end
  end

  assign partial     = flush_pend_i && (flush_idx_i != LW'(DATA_BYTES - 1)) && nxt_empty;
  assign out_valid_o = all_full || partial;
  assign out_fire_o  = out_valid_o && out_ready_i;

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_lane
    assign used[k]                = !partial || (LW'(k) <= flush_idx_i);
    assign out_data_o[8*k +: 8]   = used[k] ? head_i[k].data : 8'h00;
    assign lane_last[k]           = used[k] && head_i[k].last;
    assign pop_o[k]               = out_fire_o && used[k];
  end

  assign out_last_o = |lane_last;
endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer
  import bwp_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 4,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [7:0]              in_data_i,
  input  logic                    in_valid_i,
  input  logic                    in_last_i,
  output logic                    in_ready_o,
  output logic [8*DATA_BYTES-1:0] out_data_o,
  output logic                    out_valid_o,
  output logic                    out_last_o,
  input  logic                    out_ready_i
);
  localparam int unsigned LW = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

  logic [DATA_BYTES-1:0]        lane_push, lane_pop, lane_empty, lane_full;
  lane_entry_t [DATA_BYTES-1:0] lane_head;
  lane_entry_t                  wr_entry;
  logic                         flush_pend, out_fire;
  logic [LW-1:0]                flush_idx;

  assign wr_entry.last = in_last_i;
  assign wr_entry.data = in_data_i;

  bwp_lane_ctrl #(.DATA_BYTES(DATA_BYTES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_last_i    (in_last_i),
    .lane_full_i  (lane_full),
    .out_fire_i   (out_fire),
    .out_last_i   (out_last_o),
    .in_ready_o   (in_ready_o),
    .push_o       (lane_push),
    .flush_pend_o (flush_pend),
    .flush_idx_o  (flush_idx)
  );

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_fifo
    bwp_lane_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (lane_push[k]),
      .wdata_i (wr_entry),
      .pop_i   (lane_pop[k]),
      .rdata_o (lane_head[k]),
      .empty_o (lane_empty[k]),
      .full_o  (lane_full[k])
    );
  end

  bwp_word_asm #(.DATA_BYTES(DATA_BYTES)) u_asm (
    .head_i       (lane_head),
    .empty_i      (lane_empty),
    .flush_pend_i (flush_pend),
    .flush_idx_i  (flush_idx),
    .out_ready_i  (out_ready_i),
    .out_data_o   (out_data_o),
    .out_valid_o  (out_valid_o),
    .out_last_o   (out_last_o),
    .pop_o        (lane_pop),
    .out_fire_o   (out_fire)
  );
endmodule

// File: rtl/bwp_checker.sv
module bwp_checker #(
  parameter int unsigned DATA_BYTES = 4,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned LW = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic                    in_last_i,
  input logic                    in_ready_o,
  input logic [8*DATA_BYTES-1:0] out_data_o,
  input logic                    out_valid_o,
  input logic                    out_last_o,
  input logic                    out_ready_i,
  input logic [DATA_BYTES-1:0]   lane_push,
  input logic [DATA_BYTES-1:0]   lane_pop,
  input logic [LW-1:0]           flush_idx
);
  logic        in_fire;
  logic [15:0] held_q;

  assign in_fire = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= held_q + 16'(in_fire) - 16'($countones(lane_pop));
  end

  p_one_push_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lane_push) == (in_fire ? 1 : 0));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q <= 16'(DATA_BYTES * FIFO_DEPTH));

  p_hold_after_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fire && in_last_i) |=> !in_ready_o);

  p_stall_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

  p_pad_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_last_o && flush_idx != LW'(DATA_BYTES - 1))
      |-> ((out_data_o >> (8 * (int'(flush_idx) + 1))) == '0));
endmodule

bind byte_word_packer bwp_checker #(
  .DATA_BYTES(DATA_BYTES),
  .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_last_i   (in_last_i),
  .in_ready_o  (in_ready_o),
  .out_data_o  (out_data_o),
  .out_valid_o (out_valid_o),
  .out_last_o  (out_last_o),
  .out_ready_i (out_ready_i),
  .lane_push   (lane_push),
  .lane_pop    (lane_pop),
  .flush_idx   (flush_idx)
);

// File: tb/tb_byte_word_packer.sv
module tb_byte_word_packer;
  localparam int DB = 4;
  localparam int DEPTH = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      in_data = '0;
  logic            in_valid = 1'b0;
  logic            in_last = 1'b0;
  logic            in_ready;
  logic [8*DB-1:0] out_data;
  logic            out_valid, out_last;
  logic            out_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  int accepted = 0;
  int words_seen = 0;
  bit hold = 1'b0;

  logic [7:0]    stim_q[$];
  logic [8*DB:0] exp_q[$];

  always #2 clk = ~clk;

  byte_word_packer #(.DATA_BYTES(DB), .FIFO_DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_last_i(in_last), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_last_o(out_last), .out_ready_i(out_ready)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // expected words: {last, data} per word, lane = index mod DB, zero padding
  task automatic build_expected(input int len);
    logic [8*DB-1:0] w = '0;
    exp_q.delete();
    for (int i = 0; i < len; i++) begin
      w[8*(i%DB) +: 8] = stim_q[i];
      if ((i % DB) == DB - 1 || i == len - 1) begin
        exp_q.push_back({(i == len - 1), w});
        w = '0;
      end
    end
  endtask

  task automatic drive(input int len, input int vprob);
    int i = 0;
    while (i < len) begin
      @(negedge clk);
      if (($urandom % 100) < vprob) begin
        in_valid = 1'b1;
        in_data  = stim_q[i];
        in_last  = (i == len - 1);
      end else begin
        in_valid = 1'b0;
      end
      if (in_valid && in_ready) begin
        i++;
        accepted++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic receive(input int len, input int rprob);
    bit done = 1'b0;
    logic [8*DB:0] e;
    string req;
    while (!done) begin
      @(negedge clk);
      out_ready = hold ? 1'b0 : (($urandom % 100) < rprob);
      if (out_valid && out_ready) begin
        words_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 extra word", 64'(out_data), 64'(0));
          done = 1'b1;
        end else begin
          e = exp_q.pop_front();
          req = (e[8*DB] && (len % DB) != 0) ? "R4" : (e[8*DB] ? "R5" : "R2");
          check(out_data == e[8*DB-1:0], req, 64'(out_data), 64'(e[8*DB-1:0]));
          check(out_last == e[8*DB], "R5 last", 64'(out_last), 64'(e[8*DB]));
          if (out_last) done = 1'b1;
        end
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_stream(input int len, input int vprob, input int rprob, input bit fill);
    int nwords;
    stim_q.delete();
    for (int i = 0; i < len; i++) stim_q.push_back(fill ? 8'(8'hA0 + i) : 8'($urandom));
    build_expected(len);
    nwords = exp_q.size();
    words_seen = 0;
    fork
      drive(len, vprob);
      receive(len, rprob);
    join
    check(words_seen == nwords && exp_q.size() == 0, "R3 word count",
          64'(words_seen), 64'(nwords));
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int base;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'(1));
    check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'(0));

    // directed: single byte (R4), exact word (R5), word plus one (R2, R8 lane 0 restart)
    run_stream(1, 100, 100, 1'b1);
    run_stream(DB, 100, 100, 1'b1);
    run_stream(DB + 1, 100, 100, 1'b1);
    run_stream(2 * DB, 70, 60, 1'b0);

    // R7: output stalled, lane FIFOs fill and block input
    base = accepted;
    hold = 1'b1;
    fork
      run_stream(DB * DEPTH + 3, 100, 100, 1'b0);
      begin
        repeat (60) @(negedge clk);
        check(accepted - base == DB * DEPTH, "R7 accepted while stalled",
              64'(accepted - base), 64'(DB * DEPTH));
        check(in_ready == 1'b0, "R7 in_ready", 64'(in_ready), 64'(0));
        hold = 1'b0;
      end
    join

    // R8: after last accepted, input held off until final word leaves
    base = accepted;
    hold = 1'b1;
    fork
      run_stream(2, 100, 100, 1'b1);
      begin
        while (accepted - base < 2) @(negedge clk);
        for (int c = 0; c < 10; c++) begin
          @(negedge clk);
          check(in_ready == 1'b0, "R8 in_ready after last", 64'(in_ready), 64'(0));
        end
        hold = 1'b0;
      end
    join
    @(negedge clk);
    check(in_ready == 1'b1, "R8 in_ready restored", 64'(in_ready), 64'(1));

    // random streams, random stalls on both sides (R2 R3 R4 R5 R6 R9)
    for (int s = 0; s < 40; s++) begin
      run_stream(1 + int'($urandom % 13), 30 + int'($urandom % 71), 20 + int'($urandom % 81), 1'b0);
    end

    finish_run();
  end
endmodule